// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates a set of maskable interrupt request lines and one non-maskable request for a processor core. Each line has an enable bit and a pending bit, and software changes them through separate set-only and clear-only write ports. Each line also has a programmable priority. From the lines that are both pending and enabled, the block picks the most urgent one. It raises a request to the core when that candidate is strictly more urgent than the handler that is running.

The core takes a request by pulsing `ack_i` and signals the end of a handler by pulsing `ret_i`. The block keeps a stack of the active priority levels, so handlers can nest. It reports the vector index of the candidate and of the running handler, and a core uses that index to look up the handler address in a table. On a return, the block compares the best pending request with the level that was interrupted. If the request is more urgent, the block chains straight into it and replaces the stack top. If not, it pops the stack and restores the previous level. Saving and restoring core state is outside the block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, all enable and pending bits are 0, `depth_o` is 0, `act_lvl_o` is all ones (idle), and `req_o` and `chain_o` are 0.
- R2: On each clock edge, every 1 bit in `en_set_i` sets the matching enable bit, and every 1 bit in `en_clr_i` clears it. A 0 bit leaves the enable bit unchanged. When set and clear hit the same bit, clear wins.
- R3: On each clock edge, a 1 on `irq_i` or `pend_set_i` sets the matching pending bit, and a 1 on `pend_clr_i` clears it. Clear wins over set.
- R4: The candidate is the pending and enabled line with the numerically smallest priority, where 0 is most urgent. Among lines of equal priority, the lowest index wins. `vec_o` is 0 for the non-maskable request, k+1 for line k, and 0 when there is no candidate.
- R5: `req_o` is high exactly when a candidate exists and its level is strictly more urgent than `act_lvl_o`. A request of equal level never preempts.
- R6: `ack_i` while `req_o` is high pushes the candidate onto the stack. `depth_o` then rises by 1 and `act_lvl_o` and `act_vec_o` take the candidate's level and vector on the next cycle. The taken pending bit clears, and this clear overrides any set of that bit in the same cycle.
- R7: `nmi_i` makes a non-maskable request pending. This request ignores every enable bit, outranks every line at level 0, and cannot preempt its own handler.
- R8: `ret_i` with no chain pops the stack and restores the previous level and vector. `ret_i` at depth 0 has no effect.
- R9: `ret_i` at nonzero depth, while a candidate is more urgent than the level below the stack top, replaces the top with that candidate. Depth is unchanged, the candidate's pending bit clears, and `chain_o` is high for the next cycle.
- R10: `ack_i` has no effect when `req_o` is low or when `ret_i` is high in the same cycle.
- R11: `act_lvl_o` is 0 while the non-maskable handler runs and p+1 while a line of priority p runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N | Request lines, a 1 makes the line pending |
| nmi_i | input | 1 | Non-maskable request |
| prio_i | input | N*PW | Priority of line k in bits [k*PW +: PW] |
| en_set_i | input | N | Set-enable write, 1 acts |
| en_clr_i | input | N | Clear-enable write, 1 acts |
| pend_set_i | input | N | Set-pending write, 1 acts |
| pend_clr_i | input | N | Clear-pending write, 1 acts |
| ack_i | input | 1 | Core takes the offered request |
| ret_i | input | 1 | Core finishes the running handler |
| req_o | output | 1 | Candidate outranks the running level |
| vec_o | output | VW | Vector index of the candidate |
| act_vec_o | output | VW | Vector index of the running handler, 0 when idle |
| act_lvl_o | output | PW+1 | Running level, all ones when idle |
| depth_o | output | SPW | Number of nested handlers |
| chain_o | output | 1 | Pulse: the last return chained into a new request |
| en_o | output | N | Enable bits |
| pend_o | output | N | Pending bits |

## Verification
All state (enable, pending, non-maskable pending, stack, chain flag) updates on the clock edge where the write, request, acknowledge or return is applied. `en_o`, `pend_o`, `depth_o`, `act_lvl_o`, `act_vec_o` and `chain_o` are therefore due one cycle after that stimulus. `req_o` and `vec_o` are combinational from that registered state, so they show the new candidate in the same cycle. The bench applies each stimulus, steps its reference model in the same step, waits for one rising edge, and compares every output 2 ns after that edge. A request and its acknowledge are never sampled at the same instant.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/nest_irq_state.sv
module nest_irq_state #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         nmi_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  input  logic [N-1:0] pend_set_i,
  input  logic [N-1:0] pend_clr_i,
  input  logic [N-1:0] take_line_i,
  input  logic         take_nmi_i,
  output logic [N-1:0] en_q_o,
  output logic [N-1:0] pend_q_o,
  output logic         nmi_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= '0;
      pend_q_o <= '0;
      nmi_q_o  <= 1'b0;
    end else begin
      en_q_o   <= (en_q_o | en_set_i) & ~en_clr_i;
      // taking a line beats any set in the same cycle
      pend_q_o <= ((pend_q_o | irq_i | pend_set_i) & ~pend_clr_i) & ~take_line_i;
      nmi_q_o  <= (nmi_q_o | nmi_i) & ~take_nmi_i;
    end
  end
endmodule

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3,
  parameter int unsigned LW = PW + 1,
  parameter int unsigned VW = 4
) (
  input  logic [N-1:0]    live_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic            nmi_i,
  output logic            valid_o,
  output logic [LW-1:0]   lvl_o,
  output logic [VW-1:0]   vec_o
);
  always_comb begin
    valid_o = 1'b0;
    lvl_o   = '1;
    vec_o   = '0;
    // ascending scan with strict compare: lowest index wins ties
    for (int i = 0; i < int'(N); i++) begin
      if (live_i[i] && ((LW'(prio_i[i*PW +: PW]) + LW'(1)) < lvl_o)) begin
        valid_o = 1'b1;
        lvl_o   = LW'(prio_i[i*PW +: PW]) + LW'(1);
        vec_o   = VW'(i + 1);
      end
    end
    if (nmi_i) begin
      valid_o = 1'b1;
      lvl_o   = '0;
      vec_o   = '0;
    end
  end
endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack
  import nest_irq_pkg::*;
#(
  parameter int unsigned D   = 9,
  parameter int unsigned LW  = 4,
  parameter int unsigned VW  = 4,
  parameter int unsigned SPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  stk_op_e        op_i,
  input  logic [LW-1:0]  lvl_i,
  input  logic [VW-1:0]  vec_i,
  output logic [LW-1:0]  top_lvl_o,
  output logic [VW-1:0]  top_vec_o,
  output logic [LW-1:0]  prev_lvl_o,
  output logic [SPW-1:0] sp_o
);
  logic [LW-1:0] lvl_q [D];
  logic [VW-1:0] vec_q [D];

  for (genvar g = 0; g < int'(D); g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[g] <= '1;
        vec_q[g] <= '0;
      end else if ((op_i == STK_PUSH && sp_o == SPW'(g)) ||
                   (op_i == STK_SWAP && sp_o == SPW'(g + 1))) begin
        lvl_q[g] <= lvl_i;
        vec_q[g] <= vec_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_o <= '0;
    else if (op_i == STK_PUSH && sp_o < SPW'(D)) sp_o <= sp_o + SPW'(1);
    else if (op_i == STK_POP && sp_o != '0) sp_o <= sp_o - SPW'(1);
  end

  always_comb begin
    top_lvl_o  = '1;
    top_vec_o  = '0;
    prev_lvl_o = '1;
    for (int i = 0; i < int'(D); i++) begin
      if (sp_o == SPW'(i + 1)) begin
        top_lvl_o = lvl_q[i];
        top_vec_o = vec_q[i];
      end
      if (sp_o == SPW'(i + 2)) prev_lvl_o = lvl_q[i];
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3,
  localparam int unsigned LW  = PW + 1,
  localparam int unsigned VW  = $clog2(N + 1),
  localparam int unsigned D   = (1 << PW) + 1,
  localparam int unsigned SPW = $clog2(D + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    irq_i,
  input  logic            nmi_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [N-1:0]    en_set_i,
  input  logic [N-1:0]    en_clr_i,
  input  logic [N-1:0]    pend_set_i,
  input  logic [N-1:0]    pend_clr_i,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            req_o,
  output logic [VW-1:0]   vec_o,
  output logic [VW-1:0]   act_vec_o,
  output logic [LW-1:0]   act_lvl_o,
  output logic [SPW-1:0]  depth_o,
  output logic            chain_o,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    pend_o
);
  logic [N-1:0]   en_q, pend_q, take_line;
  logic           nmi_q, take_nmi;
  logic           cand_v;
  logic [LW-1:0]  cand_l, top_l, prev_l, cur_l;
  logic [VW-1:0]  cand_vec, top_vec;
  logic [SPW-1:0] sp;
  logic           busy, accept, chain, pop, take, chain_q;
  stk_op_e        op;

  nest_irq_state #(.N(N)) u_state (
    .clk_i, .rst_ni, .irq_i, .nmi_i, .en_set_i, .en_clr_i, .pend_set_i, .pend_clr_i,
    .take_line_i(take_line), .take_nmi_i(take_nmi),
    .en_q_o(en_q), .pend_q_o(pend_q), .nmi_q_o(nmi_q)
  );

  nest_irq_pick #(.N(N), .PW(PW), .LW(LW), .VW(VW)) u_pick (
    .live_i(en_q & pend_q), .prio_i, .nmi_i(nmi_q),
    .valid_o(cand_v), .lvl_o(cand_l), .vec_o(cand_vec)
  );

  nest_irq_stack #(.D(D), .LW(LW), .VW(VW), .SPW(SPW)) u_stack (
    .clk_i, .rst_ni, .op_i(op), .lvl_i(cand_l), .vec_i(cand_vec),
    .top_lvl_o(top_l), .top_vec_o(top_vec), .prev_lvl_o(prev_l), .sp_o(sp)
  );

  assign busy   = (sp != '0);
  assign cur_l  = busy ? top_l : '1;
  assign req_o  = cand_v && (cand_l < cur_l);
  assign accept = ack_i && req_o && !ret_i;
  // on return, chain if the best request beats the interrupted level
  assign chain  = ret_i && busy && cand_v && (cand_l < prev_l);
  assign pop    = ret_i && busy && !chain;
  assign take   = accept || chain;

  assign take_nmi  = take && (cand_vec == '0);
  assign take_line = (take && cand_vec != '0) ? (N'(1) << (cand_vec - VW'(1))) : '0;

  always_comb begin
    if (accept)     op = STK_PUSH;
    else if (chain) op = STK_SWAP;
    else if (pop)   op = STK_POP;
    else            op = STK_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 1'b0;
    else         chain_q <= chain;
  end

  assign vec_o     = cand_vec;
  assign act_vec_o = busy ? top_vec : '0;
  assign act_lvl_o = cur_l;
  assign depth_o   = sp;
  assign chain_o   = chain_q;
  assign en_o      = en_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/nest_irq_ctrl_sva.sv
module nest_irq_ctrl_sva #(
  parameter int unsigned N   = 8,
  parameter int unsigned LW  = 4,
  parameter int unsigned VW  = 4,
  parameter int unsigned SPW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ack_i,
  input logic           ret_i,
  input logic [N-1:0]   en_clr_i,
  input logic           req_o,
  input logic [VW-1:0]  vec_o,
  input logic [LW-1:0]  act_lvl_o,
  input logic [SPW-1:0] depth_o,
  input logic           chain_o,
  input logic [N-1:0]   en_o,
  input logic [N-1:0]   pend_o
);
  a_r2_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_clr_i) |=> ((en_o & $past(en_clr_i)) == '0));

  a_r4_cand_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && vec_o != '0) |-> (|((en_o & pend_o) & (N'(1) << (vec_o - VW'(1))))));

  a_r6_push_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !ret_i) |=> (depth_o == $past(depth_o) + SPW'(1)));

  a_r5_nest_strict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !ret_i) |=> (act_lvl_o < $past(act_lvl_o)));

  a_r8_idle_ret_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o == '0) |=> (depth_o == '0));

  a_r9_chain_or_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o != '0) |=> ((depth_o == $past(depth_o)) == chain_o));

  a_r10_ack_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !ret_i) |=> (depth_o == $past(depth_o)));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_sva #(.N(N), .LW(LW), .VW(VW), .SPW(SPW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .ret_i(ret_i), .en_clr_i(en_clr_i),
  .req_o(req_o), .vec_o(vec_o), .act_lvl_o(act_lvl_o), .depth_o(depth_o),
  .chain_o(chain_o), .en_o(en_o), .pend_o(pend_o)
);

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;
  localparam int N    = 8;
  localparam int PW   = 3;
  localparam int LW   = PW + 1;
  localparam int VW   = $clog2(N + 1);
  localparam int D    = (1 << PW) + 1;
  localparam int SPW  = $clog2(D + 1);
  localparam int IDLE = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0, en_set_i = '0, en_clr_i = '0, pend_set_i = '0, pend_clr_i = '0;
  logic nmi_i = 1'b0, ack_i = 1'b0, ret_i = 1'b0;
  logic [N*PW-1:0] prio_i;
  logic req_o, chain_o;
  logic [VW-1:0] vec_o, act_vec_o;
  logic [LW-1:0] act_lvl_o;
  logic [SPW-1:0] depth_o;
  logic [N-1:0] en_o, pend_o;

  always #10 clk = ~clk;

  nest_irq_ctrl #(.N(N), .PW(PW)) u_dut (
    .clk_i(clk), .rst_ni, .irq_i, .nmi_i, .prio_i, .en_set_i, .en_clr_i,
    .pend_set_i, .pend_clr_i, .ack_i, .ret_i, .req_o, .vec_o, .act_vec_o,
    .act_lvl_o, .depth_o, .chain_o, .en_o, .pend_o
  );

  int n_chk = 0, n_fail = 0;
  int m_prio [N];
  logic [N-1:0] m_en = '0, m_pend = '0;
  bit m_nmi = 0, m_chain = 0;
  int m_sl [D];
  int m_sv [D];
  int m_sp = 0;

  always_comb for (int i = 0; i < N; i++) prio_i[i*PW +: PW] = PW'(m_prio[i]);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_pick(output bit v, output int l, output int vec);
    v = 0; l = IDLE; vec = 0;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && (m_prio[i] + 1) < l) begin
        v = 1; l = m_prio[i] + 1; vec = i + 1;
      end
    if (m_nmi) begin v = 1; l = 0; vec = 0; end
  endtask

  function automatic int cur_lvl();
    return (m_sp == 0) ? IDLE : m_sl[m_sp-1];
  endfunction

  // step model with current inputs, clock once, compare all outputs
  task automatic cyc();
    bit v, req, acc, ch, pop;
    int l, vec, prev;
    m_pick(v, l, vec);
    prev = (m_sp < 2) ? IDLE : m_sl[m_sp-2];
    req  = v && (l < cur_lvl());
    acc  = ack_i && req && !ret_i;
    ch   = ret_i && (m_sp > 0) && v && (l < prev);
    pop  = ret_i && (m_sp > 0) && !ch;
    m_en   = (m_en | en_set_i) & ~en_clr_i;
    m_pend = (m_pend | irq_i | pend_set_i) & ~pend_clr_i;
    m_nmi  = m_nmi | nmi_i;
    if (acc || ch) begin
      if (vec == 0) m_nmi = 0;
      else m_pend[vec-1] = 1'b0;
    end
    if (acc) begin m_sl[m_sp] = l; m_sv[m_sp] = vec; m_sp++; end
    else if (ch) begin m_sl[m_sp-1] = l; m_sv[m_sp-1] = vec; end
    else if (pop) m_sp--;
    m_chain = ch;
    @(posedge clk); #2;
    m_pick(v, l, vec);
    chk("R2 enable bits", int'(en_o), int'(m_en));
    chk("R3 pending bits", int'(pend_o), int'(m_pend));
    chk("R5 request", int'(req_o), int'(v && l < cur_lvl()));
    chk("R4 vector", int'(vec_o), vec);
    chk("R6 R8 depth", int'(depth_o), m_sp);
    chk("R11 level", int'(act_lvl_o), cur_lvl());
    chk("R8 active vector", int'(act_vec_o), (m_sp == 0) ? 0 : m_sv[m_sp-1]);
    chk("R9 chain flag", int'(chain_o), int'(m_chain));
    irq_i = '0; en_set_i = '0; en_clr_i = '0; pend_set_i = '0; pend_clr_i = '0;
    nmi_i = 0; ack_i = 0; ret_i = 0;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_prio[0] = 5; m_prio[1] = 2; m_prio[2] = 2; m_prio[3] = 7;
    for (int i = 4; i < N; i++) m_prio[i] = 6;
    #35;
    // R1 reset state
    chk("R1 depth", int'(depth_o), 0);
    chk("R1 level idle", int'(act_lvl_o), IDLE);
    chk("R1 request", int'(req_o), 0);
    chk("R1 enable", int'(en_o), 0);
    chk("R1 pending", int'(pend_o), 0);
    chk("R1 chain", int'(chain_o), 0);
    @(posedge clk); #2; rst_ni = 1'b1;

    en_set_i = 8'h0F; cyc();
    en_clr_i = 8'h00; cyc();
    chk("R2 zero write keeps", int'(en_o), 'h0F);
    en_set_i = 8'h80; en_clr_i = 8'h80; cyc();
    chk("R2 clear wins", int'(en_o), 'h0F);

    pend_set_i = 8'h06; cyc();
    chk("R4 tie lower index", int'(vec_o), 2);
    ack_i = 1; irq_i = 8'h02; cyc();
    chk("R6 take clears bit", int'(pend_o), 'h04);
    chk("R11 level p+1", int'(act_lvl_o), 3);
    chk("R5 equal no preempt", int'(req_o), 0);
    ack_i = 1; cyc();
    chk("R10 ack without request", int'(depth_o), 1);

    pend_set_i = 8'h01; cyc();
    chk("R5 less urgent waits", int'(req_o), 0);
    nmi_i = 1; en_clr_i = '1; cyc();
    chk("R7 nmi ignores enable", int'(req_o), 1);
    chk("R7 nmi vector", int'(vec_o), 0);
    ack_i = 1; ret_i = 1; cyc();  // R10: return wins over ack, chains into nmi
    chk("R9 chain depth", int'(depth_o), 1);
    chk("R7 nmi level", int'(act_lvl_o), 0);
    chk("R9 chain pulse", int'(chain_o), 1);
    en_set_i = 8'h0F; nmi_i = 1; cyc();
    chk("R7 nmi no self preempt", int'(req_o), 0);
    ret_i = 1; cyc();
    ret_i = 1; cyc();
    chk("R9 chain to line", int'(act_vec_o), 3);
    ret_i = 1; cyc();
    ret_i = 1; cyc();
    chk("R8 pop to idle", int'(depth_o), 0);

    pend_set_i = 8'h08; cyc();
    ack_i = 1; cyc();
    pend_set_i = 8'h02; cyc();
    ack_i = 1; cyc();
    chk("R6 nested depth", int'(depth_o), 2);
    ret_i = 1; cyc();
    chk("R8 restore level", int'(act_lvl_o), 8);
    chk("R8 restore vector", int'(act_vec_o), 4);
    ret_i = 1; cyc();
    ret_i = 1; cyc();
    chk("R8 idle return ignored", int'(depth_o), 0);

    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0)
        for (int i = 0; i < N; i++) m_prio[i] = int'($urandom % (1 << PW));
      en_set_i   = ($urandom % 4 == 0) ? N'($urandom) : '0;
      en_clr_i   = ($urandom % 8 == 0) ? N'($urandom) : '0;
      pend_set_i = ($urandom % 6 == 0) ? N'($urandom) : '0;
      pend_clr_i = ($urandom % 10 == 0) ? N'($urandom) : '0;
      irq_i      = ($urandom % 5 == 0) ? (N'(1) << ($urandom % N)) : '0;
      nmi_i      = ($urandom % 40 == 0);
      ack_i      = ($urandom % 2 == 0);
      ret_i      = ($urandom % 4 == 0);
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule